// File: doc/BRIEF.md
# Programmable Video Clock Divider

This block derives three slower clocks for a display pipeline from one fast reference clock. The reference runs at twice the dot rate. A single free-running binary counter advances on every reference edge. Each output takes one bit of that counter and registers it. Because every output comes from the same counter, all of them stay phase-aligned with each other.

An 8-bit selection register sets the ratios. The register is loaded by a one-cycle write strobe together with a data bus. Each ratio field is 3 bits wide:

- Bits 5:3 set the ratio of the video-timing clock.
- Bits 2:0 set the ratio of the frame-buffer shift clock.
- Bit 7 adds a further divide-by-two to the shift clock only.

A third output, the gated shift clock, follows the shift clock but is silenced while the blank input is active. Its output-enable comes from bit 6. Writing the value 0x3F parks the outputs and clears the counter, which gives a known restart phase.

Every register write also raises a settle flag for a programmable number of reference cycles. This tells downstream logic when the new clocks can be trusted.

Top module: `vclk_divider`

## Requirements
- R1: For bits 5:3 equal to k in 0..6, `vclk_o` is a square wave with a period of 2^(k+1) reference cycles and 50% duty.
- R2: When bits 5:3 are 3'b111, `vclk_o` stays at 1.
- R3: For bits 2:0 equal to k in 0..6, `sclk_o` has a period of 2^(k+1+b7) reference cycles and 50% duty, where b7 is bit 7. Bit 7 does not change the period of `vclk_o`.
- R4: When bits 2:0 are 3'b111, `sclk_o` and `gclk_o` both stay at 0.
- R5: While the register holds exactly 8'h3F, the counter is held at zero, `vclk_o` is 1 and `sclk_o` is 0. After a write of 8'h09 that directly follows 0x3F, sampling from the write edge onward gives `sclk_o` = 0,0,0,1,1,0 and `vclk_o` = 1,0,0,1,1,0.
- R6: `gclk_oe_o` equals register bit 6. It is 0 after reset.
- R7: While `blank_i` is 0, `gclk_o` equals `sclk_o`. While `blank_i` has been 1 for several cycles, `gclk_o` is 0.
- R8: `gclk_o` is high only while `sclk_o` is high, and it rises only on a cycle where `sclk_o` also rises. Changes on `blank_i` therefore never produce a shortened pulse.
- R9: After each write, `settle_busy_o` is 1 for exactly SETTLE_CYC cycles, counted from the write edge, and then returns to 0.
- R10: After reset the register is 8'h00. Both `vclk_o` and `sclk_o` then toggle every reference cycle, and `settle_busy_o` is 0.
- R11: When both fields hold the same code and bit 7 is 0, `vclk_o` and `sclk_o` are identical on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock, twice the dot rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Write strobe for the selection register |
| cfg_wdata_i | input | 8 | Selection register write data |
| blank_i | input | 1 | Blanking indication (asynchronous), active high |
| vclk_o | output | 1 | Divided video-timing clock |
| sclk_o | output | 1 | Divided shift clock |
| gclk_o | output | 1 | Shift clock gated by blanking |
| gclk_oe_o | output | 1 | Output-enable for the gated clock |
| settle_busy_o | output | 1 | Set while the clocks settle after a write |

## Verification
The bench measures ones and rising edges over a fixed window for every ratio code, with bit 7 both clear and set:

- An off-by-one tap selection shows up as a doubled or halved edge count.
- An extra divide leaking into the video clock changes its edge count when bit 7 is set.

The clear value is checked cycle by cycle on restart. A counter that is not held at zero, or that compares only part of the register, produces a shifted 0/1 sequence.

The bench toggles blanking while the shift clock is running. Gating that is not restricted to the low phase shows up as a `gclk_o` pulse while `sclk_o` is low, or as a rising edge that `sclk_o` does not share.

A settle counter that is off by one fails the exact duration check.

// File: rtl/vcd_pkg.sv
package vcd_pkg;
   // Width of one ratio field.
   localparam int unsigned RATIO_BITS = 3;
   // Field code that parks an output at a fixed level.
   localparam logic [RATIO_BITS-1:0] PARK_CODE = '1;
   // Register layout: [7] extra shift divide, [6] gated enable,
   //                  [5:3] video ratio, [2:0] shift ratio
   localparam int unsigned REG_W = 2 * RATIO_BITS + 2;
   localparam logic [REG_W-1:0] CLEAR_VALUE = {2'b00, {(2*RATIO_BITS){1'b1}}};

   typedef struct packed {
      logic                  ext_div;
      logic                  gate_en;
      logic [RATIO_BITS-1:0] vid_code;
      logic [RATIO_BITS-1:0] shf_code;
   } vcd_cfg_t;
endpackage

// File: rtl/vcd_counter.sv
module vcd_counter #(
   parameter int unsigned CW = 8
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          clr_i,
   output logic [CW-1:0] cnt_o
);
   if (CW < 2) begin : g_bad_width
      $error("vcd_counter: CW must be at least 2");
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    cnt_o <= '0;
      else if (clr_i) cnt_o <= '0;
      else            cnt_o <= cnt_o + 1'b1;
   end

   assert_clear_holds_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> (cnt_o == '0));
   assert_free_run_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !clr_i |=> (cnt_o == $past(cnt_o) + 1'b1));
endmodule

// File: rtl/vcd_tap_sel.sv
module vcd_tap_sel #(
   parameter int unsigned CW         = 8,
   parameter int unsigned RB         = 3,
   parameter bit          HAS_EXT    = 1'b1,
   parameter bit          HOLD_LEVEL = 1'b0
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic [CW-1:0] cnt_i,
   input  logic [RB-1:0] code_i,
   input  logic          ext_i,
   output logic          nxt_o,
   output logic          out_o
);
   localparam int unsigned IW = $clog2(CW);
   localparam logic [RB-1:0] HOLD_CODE = '1;

   if (CW < (1 << RB)) begin : g_bad_cw
      $error("vcd_tap_sel: counter too narrow for ratio field");
   end

   logic          ext_eff;
   logic [IW-1:0] idx;

   if (HAS_EXT) begin : g_ext
      assign ext_eff = ext_i;
   end else begin : g_no_ext
      logic unused_ext;
      assign unused_ext = ext_i;
      assign ext_eff    = 1'b0;
   end

   always_comb begin
      idx = IW'(code_i) + IW'(ext_eff);
      if (code_i == HOLD_CODE) nxt_o = HOLD_LEVEL;
      else                     nxt_o = cnt_i[idx];
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) out_o <= 1'b0;
      else         out_o <= nxt_o;
   end

   assert_parked_level_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (code_i == HOLD_CODE) |=> (out_o == HOLD_LEVEL));
endmodule

// File: rtl/vcd_blank_gate.sv
module vcd_blank_gate #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic blank_i,
   input  logic sclk_nxt_i,
   output logic gclk_o
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("vcd_blank_gate: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   blank_s;
   logic                   open_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q <= '0;
      else         sync_q <= {sync_q[SYNC_STAGES-2:0], blank_i};
   end
   assign blank_s = sync_q[SYNC_STAGES-1];

   // The gate may only move while the shift clock is about to be low.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          open_q <= 1'b1;
      else if (!sclk_nxt_i) open_q <= !blank_s;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) gclk_o <= 1'b0;
      else         gclk_o <= sclk_nxt_i & open_q;
   end

   assert_gate_moves_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sclk_nxt_i |=> $stable(open_q));
endmodule

// File: rtl/vcd_settle.sv
module vcd_settle #(
   parameter int unsigned SETTLE_CYC = 8
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic we_i,
   output logic busy_o
);
   localparam int unsigned SW = $clog2(SETTLE_CYC + 1);

   if (SETTLE_CYC < 1) begin : g_bad_settle
      $error("vcd_settle: SETTLE_CYC must be at least 1");
   end

   logic [SW-1:0] left_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              left_q <= '0;
      else if (we_i)            left_q <= SW'(SETTLE_CYC);
      else if (left_q != '0)    left_q <= left_q - 1'b1;
   end
   assign busy_o = (left_q != '0);

   assert_busy_after_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      we_i |=> busy_o);
endmodule

// File: rtl/vclk_divider.sv
module vclk_divider #(
   parameter int unsigned SETTLE_CYC  = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                     clk_i,
   input  logic                     rst_ni,
   input  logic                     cfg_we_i,
   input  logic [vcd_pkg::REG_W-1:0] cfg_wdata_i,
   input  logic                     blank_i,
   output logic                     vclk_o,
   output logic                     sclk_o,
   output logic                     gclk_o,
   output logic                     gclk_oe_o,
   output logic                     settle_busy_o
);
   import vcd_pkg::*;

   localparam int unsigned CW = 1 << RATIO_BITS;

   vcd_cfg_t       cfg_q;
   logic [CW-1:0]  cnt;
   logic           clr;
   logic           vclk_nxt;
   logic           sclk_nxt;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       cfg_q <= '0;
      else if (cfg_we_i) cfg_q <= vcd_cfg_t'(cfg_wdata_i);
   end

   assign clr       = (cfg_q == vcd_cfg_t'(CLEAR_VALUE));
   assign gclk_oe_o = cfg_q.gate_en;

   vcd_counter #(.CW(CW)) u_cnt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (clr),
      .cnt_o (cnt)
   );

   vcd_tap_sel #(.CW(CW), .RB(RATIO_BITS), .HAS_EXT(1'b0), .HOLD_LEVEL(1'b1)) u_vid (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .cnt_i (cnt),
      .code_i(cfg_q.vid_code),
      .ext_i (cfg_q.ext_div),
      .nxt_o (vclk_nxt),
      .out_o (vclk_o)
   );

   vcd_tap_sel #(.CW(CW), .RB(RATIO_BITS), .HAS_EXT(1'b1), .HOLD_LEVEL(1'b0)) u_shf (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .cnt_i (cnt),
      .code_i(cfg_q.shf_code),
      .ext_i (cfg_q.ext_div),
      .nxt_o (sclk_nxt),
      .out_o (sclk_o)
   );

   vcd_blank_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .blank_i   (blank_i),
      .sclk_nxt_i(sclk_nxt),
      .gclk_o    (gclk_o)
   );

   vcd_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .we_i  (cfg_we_i),
      .busy_o(settle_busy_o)
   );

   logic unused_vnxt;
   assign unused_vnxt = vclk_nxt;

   assert_shift_parked_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_q.shf_code == PARK_CODE) |=> (!sclk_o && !gclk_o));
   assert_gated_inside_shift_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gclk_o |-> sclk_o);
   assert_gated_rise_aligned_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(gclk_o) |-> $rose(sclk_o));
   assert_clear_levels_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr |=> (vclk_o && !sclk_o));
endmodule

// File: tb/vclk_divider_test.sv
`timescale 1ns/1ps
module vclk_divider_test;
   localparam int SETTLE = 8;
   localparam int WIN    = 512;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       we = 1'b0;
   logic [7:0] wdata = 8'h00;
   logic       blank = 1'b0;
   logic       vclk, sclk, gclk, gclk_oe, busy;
   int         errors = 0;
   int         checks = 0;
   bit         done = 1'b0;

   always #4 clk = ~clk;

   vclk_divider #(.SETTLE_CYC(SETTLE), .SYNC_STAGES(2)) uut (
      .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_wdata_i(wdata),
      .blank_i(blank), .vclk_o(vclk), .sclk_o(sclk), .gclk_o(gclk),
      .gclk_oe_o(gclk_oe), .settle_busy_o(busy)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic write_cfg(input logic [7:0] d);
      @(negedge clk);
      we = 1'b1; wdata = d;
      @(negedge clk);
      we = 1'b0;
   endtask

   function automatic logic pick(input int sel);
      case (sel)
         0: return vclk;
         1: return sclk;
         default: return gclk;
      endcase
   endfunction

   task automatic measure(input int sel, output int ones, output int rises);
      logic prev, cur;
      ones = 0; rises = 0;
      @(negedge clk);
      prev = pick(sel);
      for (int i = 0; i < WIN; i++) begin
         @(negedge clk);
         cur = pick(sel);
         if (cur) ones++;
         if (cur && !prev) rises++;
         prev = cur;
      end
   endtask

   task automatic t_reset_state();
      int o, r;
      check("R10", "gclk_oe after reset", gclk_oe, 0);
      check("R10", "busy after reset", busy, 0);
      check("R6", "gate enable reset value", gclk_oe, 0);
      measure(0, o, r);
      check("R10", "vclk rises", r, WIN / 2);
      measure(1, o, r);
      check("R10", "sclk rises", r, WIN / 2);
   endtask

   task automatic t_vid_ratios();
      int o, r;
      for (int k = 0; k < 7; k++) begin
         write_cfg(8'((k << 3) | 7));
         repeat (4) @(negedge clk);
         measure(0, o, r);
         check("R1", $sformatf("vclk ones code %0d", k), o, WIN / 2);
         check("R1", $sformatf("vclk rises code %0d", k), r, WIN >> (k + 1));
      end
      write_cfg(8'h38);
      repeat (4) @(negedge clk);
      measure(0, o, r);
      check("R2", "vclk parked ones", o, WIN);
      check("R2", "vclk parked rises", r, 0);
   endtask

   task automatic t_shf_ratios();
      int o, r;
      for (int e = 0; e < 2; e++) begin
         for (int k = 0; k < 7; k++) begin
            write_cfg(8'((e << 7) | (2 << 3) | k));
            repeat (4) @(negedge clk);
            measure(1, o, r);
            check("R3", $sformatf("sclk ones code %0d ext %0d", k, e), o, WIN / 2);
            check("R3", $sformatf("sclk rises code %0d ext %0d", k, e), r, WIN >> (k + 1 + e));
         end
      end
      write_cfg(8'h90);
      repeat (4) @(negedge clk);
      measure(0, o, r);
      check("R3", "vclk unaffected by bit 7", r, WIN / 8);
      write_cfg(8'hC7);
      repeat (4) @(negedge clk);
      measure(1, o, r);
      check("R4", "sclk parked ones", o, 0);
      measure(2, o, r);
      check("R4", "gclk parked ones", o, 0);
   endtask

   task automatic t_clear_restart();
      logic exp_s [6] = '{0, 0, 0, 1, 1, 0};
      logic exp_v [6] = '{1, 0, 0, 1, 1, 0};
      int   bad = 0;
      write_cfg(8'h3F);
      for (int i = 0; i < 16; i++) begin
         @(negedge clk);
         if (!vclk || sclk || gclk) bad++;
      end
      check("R5", "levels while cleared", bad, 0);
      write_cfg(8'h09);
      for (int i = 0; i < 6; i++) begin
         check("R5", $sformatf("sclk restart step %0d", i), sclk, exp_s[i]);
         check("R5", $sformatf("vclk restart step %0d", i), vclk, exp_v[i]);
         @(negedge clk);
      end
   endtask

   task automatic t_alignment();
      int bad = 0;
      write_cfg(8'h1B);
      repeat (4) @(negedge clk);
      for (int i = 0; i < WIN; i++) begin
         @(negedge clk);
         if (vclk != sclk) bad++;
      end
      check("R11", "vclk/sclk mismatches", bad, 0);
   endtask

   task automatic t_gating();
      int o, r, bad, runt;
      logic ps, pg;
      write_cfg(8'h41);
      check("R6", "gclk_oe with bit 6 set", gclk_oe, 1);
      blank = 1'b0;
      repeat (8) @(negedge clk);
      bad = 0;
      for (int i = 0; i < 256; i++) begin
         @(negedge clk);
         if (gclk != sclk) bad++;
      end
      check("R7", "gclk follows sclk when unblanked", bad, 0);
      blank = 1'b1;
      repeat (8) @(negedge clk);
      measure(2, o, r);
      check("R7", "gclk ones while blanked", o, 0);
      blank = 1'b0;
      bad = 0; runt = 0;
      ps = sclk; pg = gclk;
      for (int i = 0; i < 600; i++) begin
         @(negedge clk);
         if (i % 3 == 0) blank = ~blank;
         if (gclk && !sclk) bad++;
         if (gclk && !pg && !(sclk && !ps)) runt++;
         ps = sclk; pg = gclk;
      end
      blank = 1'b0;
      check("R8", "gclk high while sclk low", bad, 0);
      check("R8", "gclk rises without sclk rise", runt, 0);
      write_cfg(8'h01);
      check("R6", "gclk_oe with bit 6 clear", gclk_oe, 0);
   endtask

   task automatic t_settle();
      int n = 0;
      write_cfg(8'h12);
      while (busy && n < 4 * SETTLE) begin
         n++;
         @(negedge clk);
      end
      check("R9", "settle cycles", n, SETTLE);
      repeat (4) @(negedge clk);
      check("R9", "busy clear later", busy, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset_state();
      t_vid_ratios();
      t_shf_ratios();
      t_clear_restart();
      t_alignment();
      t_gating();
      t_settle();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule